// File: doc/BRIEF.md
# Timer Event Status Register

This block keeps the event flags of a general-purpose timer and raises the timer's interrupt request. The timer core sends it one-cycle pulses for five kinds of event: counter overflow, a match on each of two compare values, and each of two capture events. Each pulse latches its own sticky flag. Software reads all five flags from a single 32-bit register with no wait states. To acknowledge events, software writes ones to the flags it wants cleared. A flag stays set until software clears it, whatever the interrupt enables say. The interrupt request is the OR of the flags whose enable bits are high.

A compare flag can get stuck while the timer is halted. If the counter is stopped and sits exactly on a compare value, a clear of that compare flag is refused. The flag stays set until the counter value or that compare value moves, or until the counter runs again. The check uses the live counter, compare and running inputs in the same cycle as the write.

Each flag is a two-state machine with states `FLG_IDLE` and `FLG_PENDING`. Transition RAISE goes from `FLG_IDLE` to `FLG_PENDING` on an event pulse. Transition ACK goes from `FLG_PENDING` to `FLG_IDLE` on an accepted clear. A flag stays in `FLG_PENDING` when an event arrives in the same cycle, and also when the hold condition refuses the clear. Every other input combination leaves the state unchanged.

Top module: `tmr_evt_status`

## Requirements
- R1: After reset all five flags are 0, `rd_data` is 0 and `irq` is 0.
- R2: The flag layout in `rd_data` and `wr_data` is: bit 0 overflow, bit 1 compare 0, bit 2 compare 1, bit 3 capture 0, bit 4 capture 1. Bits 31 to 5 of `rd_data` always read 0. `evt_pulse` and `irq_en` use the same bit order.
- R3: A high `evt_pulse` bit sets its flag at the next clock edge, whatever the value of `irq_en`.
- R4: A write with a 1 in the position of a set flag clears that flag at the next clock edge. Its contribution to `irq` goes away at the same edge.
- R5: A 0 in a write bit leaves that flag unchanged.
- R6: A 1 written to a flag that is already clear leaves it at 0, and `irq` does not change.
- R7: If an event pulse and a clearing write for the same flag arrive in the same cycle, the flag ends that cycle at 1.
- R8: While `tmr_running` is 0 and `cnt_value` equals `cmp0_value`, a write of 1 to bit 1 does not clear it. The same rule applies to bit 2 with `cmp1_value`.
- R9: A compare flag held by R8 clears normally once the counter value changes, once its compare value changes, or once `tmr_running` is 1.
- R10: `irq` is 1 exactly when at least one flag is set and has its `irq_en` bit high. It follows changes of `irq_en` with no clock delay.
- R11: The hold rule never blocks the clearing of the overflow flag or the capture flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | 5 | One-cycle event pulses from the timer core, in the R2 bit order |
| tmr_running | input | 1 | High while the timer counter is running |
| cnt_value | input | CNT_W | Current counter value |
| cmp0_value | input | CNT_W | Compare value 0 |
| cmp1_value | input | CNT_W | Compare value 1 |
| wr_en | input | 1 | Write strobe for the status register |
| wr_data | input | DATA_W | Write data; a 1 requests the clear of that flag |
| rd_data | output | DATA_W | Current flags, zero-extended |
| irq_en | input | 5 | Interrupt enable per flag |
| irq | output | 1 | Combined interrupt request |

## Verification
Some rules are checked by the bound assertions on every cycle:
- an event pulse always leaves its flag set;
- a cycle without a write never clears a flag;
- the upper bits stay zero;
- `irq` always equals the masked OR of the flags;
- a clear of overflow without a competing event always takes effect;
- a compare flag under the stopped-and-matching condition is never cleared.

The directed scenarios are needed to show the behaviour that depends on a sequence of stimuli. These are:
- that a refused clear works after the counter moves, after the compare value moves, or after the timer runs again;
- that writing to already-clear flags changes nothing;
- that an event beats a clear in the same cycle;
- that the hold on compare flags leaves the overflow and capture flags alone.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

    // Number of event flags and their bit positions in the register.
    localparam int N_EVT    = 5;
    localparam int IDX_OVF  = 0;
    localparam int IDX_CMP0 = 1;
    localparam int IDX_CMP1 = 2;
    localparam int IDX_CAP0 = 3;
    localparam int IDX_CAP1 = 4;

    typedef enum logic {
        FLG_IDLE    = 1'b0,
        FLG_PENDING = 1'b1
    } flag_state_t;

endpackage

// File: rtl/tmr_evt_hold.sv
// Detects the stopped-timer compare match that blocks clearing a compare flag.
module tmr_evt_hold #(
    parameter int CNT_W = 16
) (
    input  logic             running_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             hold_o
);

    always_comb begin
        hold_o = !running_i && (cnt_i == cmp_i);
    end

endmodule

// File: rtl/tmr_evt_flag.sv
// One sticky event flag: RAISE on event, ACK on an accepted clear.
module tmr_evt_flag
    import tmr_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_req_i,
    input  logic hold_i,
    output logic pending_o
);

    flag_state_t state_q;
    flag_state_t state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (set_i) begin
                    state_d = FLG_PENDING;           // RAISE
                end
            end
            FLG_PENDING: begin
                if (clr_req_i && !set_i && !hold_i) begin
                    state_d = FLG_IDLE;              // ACK
                end
            end
            default: state_d = FLG_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        pending_o = (state_q == FLG_PENDING);
    end

endmodule

// File: rtl/tmr_evt_irq.sv
// Masked OR of the flags into one interrupt request.
module tmr_evt_irq #(
    parameter int N = 5
) (
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);

    always_comb begin
        irq_o = |(flags_i & en_i);
    end

endmodule

// File: rtl/tmr_evt_status.sv
module tmr_evt_status
    import tmr_evt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        evt_pulse,
    input  logic              tmr_running,
    input  logic [CNT_W-1:0]  cnt_value,
    input  logic [CNT_W-1:0]  cmp0_value,
    input  logic [CNT_W-1:0]  cmp1_value,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [4:0]        irq_en,
    output logic              irq
);

    localparam int PAD_W = DATA_W - N_EVT;

    logic [N_EVT-1:0] flags;
    logic [N_EVT-1:0] clr_req;
    logic             hold_cmp0;
    logic             hold_cmp1;
    logic             unused_wr_hi;

    assign clr_req      = wr_en ? wr_data[N_EVT-1:0] : '0;
    assign unused_wr_hi = ^wr_data[DATA_W-1:N_EVT];

    tmr_evt_hold #(.CNT_W(CNT_W)) u_hold0 (
        .running_i (tmr_running),
        .cnt_i     (cnt_value),
        .cmp_i     (cmp0_value),
        .hold_o    (hold_cmp0)
    );

    tmr_evt_hold #(.CNT_W(CNT_W)) u_hold1 (
        .running_i (tmr_running),
        .cnt_i     (cnt_value),
        .cmp_i     (cmp1_value),
        .hold_o    (hold_cmp1)
    );

    for (genvar gi = 0; gi < N_EVT; gi++) begin : g_flag
        logic hold_sel;
        if (gi == IDX_CMP0) begin : g_h0
            assign hold_sel = hold_cmp0;
        end else if (gi == IDX_CMP1) begin : g_h1
            assign hold_sel = hold_cmp1;
        end else begin : g_hn
            assign hold_sel = 1'b0;
        end

        tmr_evt_flag u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (evt_pulse[gi]),
            .clr_req_i (clr_req[gi]),
            .hold_i    (hold_sel),
            .pending_o (flags[gi])
        );
    end

    tmr_evt_irq #(.N(N_EVT)) u_irq (
        .flags_i (flags),
        .en_i    (irq_en),
        .irq_o   (irq)
    );

    assign rd_data = {{PAD_W{1'b0}}, flags};

endmodule

// File: rtl/tmr_evt_status_chk.sv
module tmr_evt_status_chk #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        evt_pulse,
    input logic              tmr_running,
    input logic [CNT_W-1:0]  cnt_value,
    input logic [CNT_W-1:0]  cmp0_value,
    input logic [CNT_W-1:0]  cmp1_value,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [4:0]        irq_en,
    input logic              irq
);

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:5] == '0);

    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != 5'd0) |=> ((rd_data[4:0] & $past(evt_pulse)) == $past(evt_pulse)));

    a_r5_no_write_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((rd_data[4:0] & $past(rd_data[4:0])) == $past(rd_data[4:0])));

    a_r4_ovf_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[0] && !evt_pulse[0]) |=> !rd_data[0]);

    a_r8_hold_cmp0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1] && !tmr_running && cnt_value == cmp0_value) |=> rd_data[1]);

    a_r8_hold_cmp1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2] && !tmr_running && cnt_value == cmp1_value) |=> rd_data[2]);

    a_r10_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((rd_data[4:0] & irq_en) != 5'd0));

endmodule

bind tmr_evt_status tmr_evt_status_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_pulse   (evt_pulse),
    .tmr_running (tmr_running),
    .cnt_value   (cnt_value),
    .cmp0_value  (cmp0_value),
    .cmp1_value  (cmp1_value),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .irq_en      (irq_en),
    .irq         (irq)
);

// File: tb/tb_tmr_evt_status.sv
module tb_tmr_evt_status;

    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4:0]        evt_pulse = '0;
    logic              tmr_running = 1'b1;
    logic [CNT_W-1:0]  cnt_value = '0;
    logic [CNT_W-1:0]  cmp0_value = 16'h0100;
    logic [CNT_W-1:0]  cmp1_value = 16'h0200;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [4:0]        irq_en = '0;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    tmr_evt_status #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
        .clk, .rst_n, .evt_pulse, .tmr_running, .cnt_value,
        .cmp0_value, .cmp1_value, .wr_en, .wr_data, .rd_data,
        .irq_en, .irq
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [4:0] m);
        @(negedge clk); evt_pulse = m;
        @(negedge clk); evt_pulse = '0;
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic clear_all();
        tmr_running = 1'b1;
        wr(32'h1F);
    endtask

    task automatic t_reset();
        check("R1 flags", rd_data, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_layout();
        irq_en = '0;
        for (int i = 0; i < 5; i++) begin
            pulse(5'd1 << i);
            check("R2 bit position", rd_data, 32'h1 << i);
            check("R3 set with enables off", {31'b0, irq}, 32'h0);
            clear_all();
        end
        pulse(5'h1F);
        check("R2 upper bits zero", rd_data, 32'h1F);
        clear_all();
        check("R4 clear all", rd_data, 32'h0);
    endtask

    task automatic t_clear_partial();
        pulse(5'h1B);
        wr(32'hFFFF_FFE9);   // 1s on bits 0 and 3 among the low five
        check("R4 R5 selective clear", rd_data, 32'h12);
        wr(32'h0);
        check("R5 write zero", rd_data, 32'h12);
        clear_all();
    endtask

    task automatic t_clear_on_clear();
        pulse(5'h04);
        irq_en = 5'h1F;
        wr(32'h1B);
        check("R6 clear flags untouched", rd_data, 32'h04);
        check("R6 irq unchanged", {31'b0, irq}, 32'h1);
        wr(32'h04);
        check("R4 irq drops", {31'b0, irq}, 32'h0);
        irq_en = '0;
    endtask

    task automatic t_collision();
        pulse(5'h08);
        @(negedge clk); evt_pulse = 5'h08; wr_en = 1'b1; wr_data = 32'h08;
        @(negedge clk); evt_pulse = '0; wr_en = 1'b0; wr_data = '0;
        check("R7 event beats clear", rd_data, 32'h08);
        clear_all();
    endtask

    task automatic t_hold_cnt();
        tmr_running = 1'b0; cnt_value = 16'h0100; cmp0_value = 16'h0100;
        pulse(5'h03);
        wr(32'h03);
        check("R8 cmp0 held, R11 ovf clears", rd_data, 32'h02);
        cnt_value = 16'h0101;
        wr(32'h02);
        check("R9 release by counter", rd_data, 32'h0);
    endtask

    task automatic t_hold_cmp();
        tmr_running = 1'b0; cnt_value = 16'h0200; cmp1_value = 16'h0200;
        pulse(5'h1C);
        wr(32'h1C);
        check("R8 cmp1 held, R11 capture clears", rd_data, 32'h04);
        cmp1_value = 16'h0300;
        wr(32'h04);
        check("R9 release by compare", rd_data, 32'h0);
    endtask

    task automatic t_hold_run();
        tmr_running = 1'b0; cnt_value = 16'h0100; cmp0_value = 16'h0100;
        pulse(5'h02);
        wr(32'h02);
        check("R8 cmp0 held again", rd_data, 32'h02);
        tmr_running = 1'b1;
        wr(32'h02);
        check("R9 release by running", rd_data, 32'h0);
        cmp0_value = 16'h0500;
    endtask

    task automatic t_irq();
        pulse(5'h11);
        irq_en = 5'h02;
        #1 check("R10 masked off", {31'b0, irq}, 32'h0);
        irq_en = 5'h10;
        #1 check("R10 cap1 enabled", {31'b0, irq}, 32'h1);
        irq_en = 5'h01;
        #1 check("R10 ovf enabled", {31'b0, irq}, 32'h1);
        wr(32'h01);
        check("R10 irq after ovf clear", {31'b0, irq}, 32'h0);
        irq_en = '0;
        clear_all();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_clear_partial();
        t_clear_on_clear();
        t_collision();
        t_hold_cnt();
        t_hold_cmp();
        t_hold_run();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule